// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit timer fed through an 8-bit prescaler, intended for a small microcontroller core. Count events come either from a one-cycle instruction strobe or from a slow external level input. The slow input first passes through a two-flop synchroniser and an edge-tracking state machine, so it can be counted on its rising or its falling transitions. The prescaler counts every source event. A 3-bit ratio field picks one of eight prescaler bits, and the timer advances whenever that bit drops from 1 to 0. A bypass bit makes the timer advance on every source event.

Software sees three registers on a simple write-strobe bus with combinational read data: the timer, a control register, and the prescaler, which is read-only. Any write to the timer clears the prescaler. With ratio 1:256 selected, the timer and the prescaler together form a 16-bit count. An overflow flag is set when the timer wraps and stays set until software clears it.

The edge tracker has two states. LVL_LOW means the synchronised input was last seen low. LVL_HIGH means it was last seen high. The transition LVL_LOW→LVL_HIGH yields a count event when rising is selected. The transition LVL_HIGH→LVL_LOW yields a count event when falling is selected. A state that sees no level change stays where it is and yields no event.

Top module: `presc_timer`

## Requirements
- R1: After reset the timer, the prescaler, every control bit and the overflow flag read zero. The default source is the instruction strobe and the default edge is rising.
- R2: The timer is at address 0x1 and can be read and written. Control is at address 0x2: bits 2:0 hold the ratio, bit 3 is bypass, bit 4 selects the slow input, bit 5 selects falling edges and bit 6 is the overflow flag. The prescaler is at address 0xF and is read-only, so writes to it are ignored. Any other address reads 0.
- R3: With the instruction source and bypass set, the timer rises by one on each clock edge where `icyc_en` is 1 and holds otherwise.
- R4: With bypass clear and ratio n, the timer advances on the source event that carries prescaler bit n from 1 to 0, which is once every 2^(n+1) events.
- R5: The prescaler rises by one on every source event, whatever the bypass and ratio settings. With ratio 7, {timer, prescaler} counts source events as one 16-bit value.
- R6: A timer write loads the written value and clears the prescaler. A count event in the same cycle is discarded.
- R7: A timer advance from 0xFF gives 0x00 and sets the overflow flag, which also appears on `ovf_flag`.
- R8: Writing 0 to control bit 6 clears the flag and writing 1 leaves it unchanged. An overflow in the same cycle as a clearing write leaves the flag set.
- R9: With the slow input selected, only the chosen edge of `lf_in` counts, and `icyc_en` is ignored.
- R10: Take as clock 0 the rising clock edge that first samples a new level on `lf_in`. The counter changes on clock 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| icyc_en | input | 1 | One-cycle instruction-cycle strobe |
| lf_in | input | 1 | Asynchronous low-frequency count input |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 3-bit ratio field and a two-stage synchroniser. With these values the full 1:256 ratio can be reached in a few hundred strobes. That makes it practical to check the 16-bit combined count across two prescaler wraps, and to count clock edges exactly to confirm the two-clock synchroniser latency on both edge polarities.

// File: rtl/presc_timer_pkg.sv
package presc_timer_pkg;
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/presc_timer_edge.sv
module presc_timer_edge
    import presc_timer_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lf_in,
    input  logic fall_sel,
    output logic edge_tick
);
    logic [STAGES-1:0] sync_q;
    logic              synced;
    lvl_state_e        state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], lf_in};
    end

    assign synced = sync_q[STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // next state and output
    always_comb begin
        state_d   = state_q;
        edge_tick = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (synced) begin
                    state_d   = LVL_HIGH;
                    edge_tick = !fall_sel;
                end
            end
            LVL_HIGH: begin
                if (!synced) begin
                    state_d   = LVL_LOW;
                    edge_tick = fall_sel;
                end
            end
            default: state_d = LVL_LOW;
        endcase
    end

    // R9
    edge_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_tick |-> (synced != $past(synced)));

    // R9
    edge_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_tick |-> (synced == !fall_sel));
endmodule

// File: rtl/presc_timer_prescaler.sv
module presc_timer_prescaler #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             src_tick,
    input  logic [SEL_W-1:0] ratio,
    output logic [PRE_W-1:0] pre_q,
    output logic             tap_tick
);
    localparam int TAPS = 1 << SEL_W;

    logic [TAPS-1:0] low_ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pre_q <= '0;
        else if (clr)      pre_q <= '0;
        else if (src_tick) pre_q <= pre_q + 1'b1;
    end

    // tap i falls on the next increment when bits i..0 are all ones
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        if (i < PRE_W) begin : g_real
            assign low_ones[i] = &pre_q[i:0];
        end else begin : g_none
            assign low_ones[i] = 1'b0;
        end
    end

    assign tap_tick = src_tick & low_ones[ratio];

    // R6
    pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));

    // R4
    tap_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_tick && !clr) |=> !pre_q[$past(ratio)]);
endmodule

// File: rtl/presc_timer.sv
module presc_timer #(
    parameter int                   DATA_W      = 8,
    parameter int                   ADDR_W      = 4,
    parameter int                   SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0]    ADDR_TMR    = 4'h1,
    parameter logic [ADDR_W-1:0]    ADDR_CTL    = 4'h2,
    parameter logic [ADDR_W-1:0]    ADDR_PRE    = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              icyc_en,
    input  logic              lf_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ovf_flag
);
    localparam int SEL_W    = $clog2(DATA_W);
    localparam int BIT_BYP  = SEL_W;
    localparam int BIT_SRC  = SEL_W + 1;
    localparam int BIT_FALL = SEL_W + 2;
    localparam int BIT_OVF  = SEL_W + 3;
    localparam int CTL_W    = SEL_W + 4;

    logic [DATA_W-1:0] tmr_q;
    logic [DATA_W-1:0] pre_q;
    logic [SEL_W-1:0]  ratio_q;
    logic              byp_q, src_q, fall_q, ovf_q;
    logic              tmr_wr, ctl_wr;
    logic              lf_tick, src_tick, tap_tick, inc, wrap;
    logic [CTL_W-1:0]  ctl_rd;

    assign tmr_wr = bus_wr && (bus_addr == ADDR_TMR);
    assign ctl_wr = bus_wr && (bus_addr == ADDR_CTL);

    presc_timer_edge #(
        .STAGES(SYNC_STAGES)
    ) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lf_in    (lf_in),
        .fall_sel (fall_q),
        .edge_tick(lf_tick)
    );

    assign src_tick = src_q ? lf_tick : icyc_en;

    presc_timer_prescaler #(
        .PRE_W(DATA_W),
        .SEL_W(SEL_W)
    ) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_wr),
        .src_tick(src_tick),
        .ratio   (ratio_q),
        .pre_q   (pre_q),
        .tap_tick(tap_tick)
    );

    assign inc  = byp_q ? src_tick : tap_tick;
    assign wrap = inc && !tmr_wr && (tmr_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tmr_q <= '0;
        else if (tmr_wr) tmr_q <= bus_wdata;
        else if (inc)    tmr_q <= tmr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= '0;
            byp_q   <= 1'b0;
            src_q   <= 1'b0;
            fall_q  <= 1'b0;
        end else if (ctl_wr) begin
            ratio_q <= bus_wdata[SEL_W-1:0];
            byp_q   <= bus_wdata[BIT_BYP];
            src_q   <= bus_wdata[BIT_SRC];
            fall_q  <= bus_wdata[BIT_FALL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             ovf_q <= 1'b0;
        else if (wrap)                          ovf_q <= 1'b1;
        else if (ctl_wr && !bus_wdata[BIT_OVF]) ovf_q <= 1'b0;
    end

    assign ctl_rd   = {ovf_q, fall_q, src_q, byp_q, ratio_q};
    assign ovf_flag = ovf_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_TMR)      bus_rdata = tmr_q;
        else if (bus_addr == ADDR_CTL) bus_rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_rd};
        else if (bus_addr == ADDR_PRE) bus_rdata = pre_q;
    end

    // R6
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> (tmr_q == $past(bus_wdata)));

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !tmr_wr && tmr_q == '1) |=> (ovf_flag && tmr_q == '0));

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(ctl_wr && !bus_wdata[BIT_OVF])) |=> ovf_flag);

    // R3
    tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !icyc_en && !src_q) |=> $stable(tmr_q));
endmodule

// File: tb/presc_timer_tb_top.sv
module presc_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       icyc_en = 1'b0;
    logic       lf_in = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ovf_flag;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    presc_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .icyc_en  (icyc_en),
        .lf_in    (lf_in),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ovf_flag (ovf_flag)
    );

    // {req[30:27], wr[26], addr[25:22], wdata[21:14], icyc[13], lf[12], raddr[11:8], exp[7:0]}
    localparam int NV = 33;
    localparam logic [30:0] VEC [NV] = '{
        {4'd1,  1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'h1, 8'h00}, // R1
        {4'd1,  1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'h2, 8'h00}, // R1
        {4'd1,  1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'hF, 8'h00}, // R1
        {4'd2,  1'b1, 4'h2, 8'h08, 1'b0, 1'b0, 4'h2, 8'h08}, // R2 bypass on
        {4'd3,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h1, 8'h01}, // R3
        {4'd3,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h1, 8'h02}, // R3
        {4'd3,  1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'h1, 8'h02}, // R3 no strobe
        {4'd5,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'hF, 8'h03}, // R5
        {4'd6,  1'b1, 4'h1, 8'h10, 1'b0, 1'b0, 4'hF, 8'h00}, // R6 clear
        {4'd2,  1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'h1, 8'h10}, // R2
        {4'd6,  1'b1, 4'h1, 8'hFE, 1'b1, 1'b0, 4'h1, 8'hFE}, // R6 write wins
        {4'd6,  1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'hF, 8'h00}, // R6
        {4'd3,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h1, 8'hFF}, // R3
        {4'd7,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h2, 8'h48}, // R7 wrap
        {4'd7,  1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'h1, 8'h00}, // R7
        {4'd8,  1'b1, 4'h2, 8'h48, 1'b0, 1'b0, 4'h2, 8'h48}, // R8 write 1 no effect
        {4'd8,  1'b1, 4'h2, 8'h08, 1'b0, 1'b0, 4'h2, 8'h08}, // R8 clear
        {4'd2,  1'b1, 4'hF, 8'h55, 1'b0, 1'b0, 4'hF, 8'h02}, // R2 prescaler read-only
        {4'd4,  1'b1, 4'h2, 8'h00, 1'b0, 1'b0, 4'h2, 8'h00}, // R4 ratio 1:2
        {4'd4,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h1, 8'h00}, // R4
        {4'd4,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h1, 8'h01}, // R4
        {4'd5,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'hF, 8'h05}, // R5
        {4'd4,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h1, 8'h02}, // R4
        {4'd7,  1'b1, 4'h1, 8'hFF, 1'b0, 1'b0, 4'h1, 8'hFF}, // R7
        {4'd7,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h2, 8'h00}, // R7
        {4'd7,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h2, 8'h40}, // R7 prescaled wrap
        {4'd8,  1'b1, 4'h1, 8'hFF, 1'b0, 1'b0, 4'h1, 8'hFF}, // R8
        {4'd8,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h2, 8'h40}, // R8
        {4'd8,  1'b1, 4'h2, 8'h00, 1'b1, 1'b0, 4'h2, 8'h40}, // R8 set wins
        {4'd8,  1'b1, 4'h2, 8'h00, 1'b0, 1'b0, 4'h2, 8'h00}, // R8
        {4'd4,  1'b1, 4'h2, 8'h01, 1'b0, 1'b0, 4'h2, 8'h01}, // R4 ratio 1:4
        {4'd4,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h1, 8'h00}, // R4
        {4'd4,  1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h1, 8'h01}  // R4
    };

    task automatic check_rd(input logic [3:0] a, input logic [7:0] e, input string req);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, e);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic strobes(input int n);
        repeat (n) begin
            @(negedge clk);
            icyc_en = 1'b1;
        end
        @(negedge clk);
        icyc_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all R) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr    = VEC[i][26];
            bus_addr  = VEC[i][25:22];
            bus_wdata = VEC[i][21:14];
            icyc_en   = VEC[i][13];
            lf_in     = VEC[i][12];
            @(negedge clk);
            bus_wr  = 1'b0;
            icyc_en = 1'b0;
            check_rd(VEC[i][11:8], VEC[i][7:0], $sformatf("R%0d", VEC[i][30:27]));
        end

        // R2 unmapped address
        check_rd(4'h0, 8'h00, "R2");

        // R5 / R4 ratio 1:256, 16-bit combined count
        bus_write(4'h2, 8'h07);
        bus_write(4'h1, 8'h00);
        strobes(255);
        check_rd(4'h1, 8'h00, "R5");
        check_rd(4'hF, 8'hFF, "R5");
        strobes(1);
        check_rd(4'h1, 8'h01, "R4");
        check_rd(4'hF, 8'h00, "R4");
        strobes(344);
        check_rd(4'h1, 8'h02, "R5");
        check_rd(4'hF, 8'h58, "R5");
        n_chk++;
        if (ovf_flag !== 1'b0) begin
            n_bad++;
            $display("FAIL R7 ovf_flag actual=%b expected=0", ovf_flag);
        end

        // R9 / R10 slow input, rising edge, bypass
        bus_write(4'h2, 8'h18);
        bus_write(4'h1, 8'h00);
        icyc_en = 1'b1;
        idle(1);
        lf_in = 1'b1;
        idle(2);
        check_rd(4'h1, 8'h00, "R10");
        idle(1);
        check_rd(4'h1, 8'h01, "R10");
        lf_in = 1'b0;
        idle(4);
        check_rd(4'h1, 8'h01, "R9");

        // R9 / R10 falling edge
        bus_write(4'h2, 8'h38);
        lf_in = 1'b1;
        idle(4);
        check_rd(4'h1, 8'h01, "R9");
        lf_in = 1'b0;
        idle(2);
        check_rd(4'h1, 8'h01, "R10");
        idle(1);
        check_rd(4'h1, 8'h02, "R10");
        icyc_en = 1'b0;

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        check_rd(4'h1, 8'h00, "R1");
        check_rd(4'h2, 8'h00, "R1");
        check_rd(4'hF, 8'h00, "R1");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule